// File: doc/BRIEF.md
# Timekeeping Byte Memory with Double-Buffered Clock Registers

This block is a byte-wide memory slave. It combines a plain storage array with eight calendar/clock registers that replace the eight highest addresses of the space. The registers a host reads and writes are a user-facing copy of a set of running calendar counters. While neither halt bit is set, that copy follows the counters on every clock. Setting the freeze bit holds the copy steady so a multi-byte time can be read coherently, and the counters keep running underneath. Setting the set bit lets software stage a new time in the copy. Clearing the set bit moves the staged time into the counters in one step.

Time advances on a one-cycle `sec_tick` pulse from an external timebase. A `hz512_tick` pulse drives a square wave that can be shown on the seconds byte for frequency checks. A stop bit halts both the counters and the square wave. A battery-status input appears as a read-only flag. Register bits with no timekeeping duty behave as ordinary storage. Accesses are synchronous, and read data appears one clock after the read strobe.

Top module: `tkram_top`

## Requirements
- R1: After reset `rd_valid` and `rd_data` are 0, and `rd_valid` is 1 exactly in the cycle after a read access (`ce_n`=0, `we_n`=1, `oe_n`=0); `rd_data` is 0 whenever `rd_valid` is 0.
- R2: A write (`ce_n`=0, `we_n`=0) below the register window stores the byte, and a later read of that address returns it, including the address just below the window.
- R3: The window is the eight top addresses (base = all ones with low three bits 0, i.e. 0x7F8 for the default 11-bit address); offsets 0..7 are control/century, seconds, minutes, hours, weekday, day-of-month, month, year, all BCD; after reset the time reads century 20, year 00, month 01, date 01, weekday 1, 00:00:00.
- R4: Each `sec_tick` pulse while running advances the seconds by one in BCD (9 carries into the tens digit).
- R5: Control bit 7 is the set bit: while it is 1, time fields are writable; writing the control byte with bit 7 cleared loads all staged fields (century from control bits 5:0) into the counters.
- R6: Rollover carries seconds 59, minutes 59, hours 23, month end (28/29/30/31, February has 29 when the year is divisible by four), month 12 and year 99 into the next field; weekday counts 1..7 and wraps to 1; century counts up.
- R7: Control bit 6 is the freeze bit: while it is 1 the user bytes keep the time of the moment it was set, the counters keep counting, and after it clears the bytes show the current count.
- R8: While neither halt bit is set, writes to time fields have no effect.
- R9: Bits without a function (minutes b7, hours b7:6, weekday b5:3, date b7:6, month b7:5) are always writable and read back as written.
- R10: Seconds bit 7 is the stop bit: while it is 1 the counters do not advance on `sec_tick`, and the bit reads back as written.
- R11: Weekday bit 6 is the test bit: while it is 1 and the stop bit is 0, seconds bit 0 reads the 512 Hz square wave, which starts at 0 after reset and toggles on each `hz512_tick`; with the stop bit set the real seconds bit is read.
- R12: Weekday bit 7 reads `batt_ok` and cannot be written.
- R13: With `ce_n`=1 no access happens: no write lands and `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after a read access |
| sec_tick | input | 1 | One-cycle pulse per second |
| hz512_tick | input | 1 | One-cycle pulse at 512 Hz |
| batt_ok | input | 1 | Battery good status |

## Verification
The calendar is tried with several loaded start times. A plain minute boundary in a non-leap February separates the 28-day month end from the leap case. A leap February 28 checks that 29 is reached. A last-second-of-year case checks the carry chain through to the century. Writes of the same byte patterns with no halt bit, with the set bit and with the stop bit separate time fields, spare storage bits and control bits. Freeze-then-tick sequences show that the snapshot holds while the counters keep running. Square-wave reads with the oscillator running and stopped separate the test override from the real seconds value.

// File: rtl/tkram_pkg.sv
package tkram_pkg;

   localparam int unsigned REG_CNT = 8;

   localparam logic [2:0] IX_CTRL = 3'd0;
   localparam logic [2:0] IX_SEC  = 3'd1;
   localparam logic [2:0] IX_MIN  = 3'd2;
   localparam logic [2:0] IX_HOUR = 3'd3;
   localparam logic [2:0] IX_DAY  = 3'd4;
   localparam logic [2:0] IX_DATE = 3'd5;
   localparam logic [2:0] IX_MON  = 3'd6;
   localparam logic [2:0] IX_YEAR = 3'd7;

   typedef struct packed {
      logic [5:0] cen;
      logic [7:0] yr;
      logic [4:0] mon;
      logic [5:0] date;
      logic [2:0] dow;
      logic [5:0] hr;
      logic [6:0] mn;
      logic [6:0] sc;
   } tk_time_t;

   // bits of each byte that belong to the running time
   function automatic logic [7:0] time_mask(input logic [2:0] ix);
      case (ix)
         IX_CTRL: return 8'h3F;
         IX_SEC:  return 8'h7F;
         IX_MIN:  return 8'h7F;
         IX_HOUR: return 8'h3F;
         IX_DAY:  return 8'h07;
         IX_DATE: return 8'h3F;
         IX_MON:  return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

   // control bits: always writable, never refreshed
   function automatic logic [7:0] ctl_mask(input logic [2:0] ix);
      case (ix)
         IX_CTRL: return 8'hC0;
         IX_SEC:  return 8'h80;
         IX_DAY:  return 8'h40;
         default: return 8'h00;
      endcase
   endfunction

   // bits supplied from outside on read, never written
   function automatic logic [7:0] ro_mask(input logic [2:0] ix);
      return (ix == IX_DAY) ? 8'h80 : 8'h00;
   endfunction

   function automatic logic [7:0] time_field(input tk_time_t t, input logic [2:0] ix);
      case (ix)
         IX_CTRL: return {2'b00, t.cen};
         IX_SEC:  return {1'b0, t.sc};
         IX_MIN:  return {1'b0, t.mn};
         IX_HOUR: return {2'b00, t.hr};
         IX_DAY:  return {5'b00000, t.dow};
         IX_DATE: return {2'b00, t.date};
         IX_MON:  return {3'b000, t.mon};
         default: return t.yr;
      endcase
   endfunction

   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
      return v + 8'd1;
   endfunction

   function automatic logic [5:0] month_end(input logic [4:0] mon, input logic [7:0] yr);
      logic [1:0] rem4;
      rem4 = {yr[4], 1'b0} + yr[1:0];
      case (mon)
         5'h02:                      return (rem4 == 2'b00) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/tkram_store.sv
module tkram_store #(
   parameter int ADDR_W  = 11,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        q
);
   localparam int DEPTH = 2 ** ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   generate
      if (OUT_REG) begin : g_qreg
         always_ff @(posedge clk) begin
            if (re) q <= mem[addr];
         end
      end else begin : g_areg
         logic [ADDR_W-1:0] addr_q;
         always_ff @(posedge clk) begin
            if (re) addr_q <= addr;
         end
         assign q = mem[addr_q];
      end
   endgenerate
endmodule

// File: rtl/tkram_calendar.sv
module tkram_calendar
   import tkram_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv,
   input  logic     load,
   input  tk_time_t load_val,
   output tk_time_t now
);
   localparam tk_time_t START = '{cen: 6'h20, yr: 8'h00, mon: 5'h01, date: 6'h01,
                                  dow: 3'h1, hr: 6'h00, mn: 7'h00, sc: 7'h00};

   tk_time_t nxt;

   always_comb begin
      nxt = now;
      if (now.sc != 7'h59) begin
         nxt.sc = 7'(bcd_step({1'b0, now.sc}));
      end else begin
         nxt.sc = 7'h00;
         if (now.mn != 7'h59) begin
            nxt.mn = 7'(bcd_step({1'b0, now.mn}));
         end else begin
            nxt.mn = 7'h00;
            if (now.hr != 6'h23) begin
               nxt.hr = 6'(bcd_step({2'b00, now.hr}));
            end else begin
               nxt.hr  = 6'h00;
               nxt.dow = (now.dow >= 3'd7) ? 3'd1 : now.dow + 3'd1;
               if (now.date < month_end(now.mon, now.yr)) begin
                  nxt.date = 6'(bcd_step({2'b00, now.date}));
               end else begin
                  nxt.date = 6'h01;
                  if (now.mon < 5'h12) begin
                     nxt.mon = 5'(bcd_step({3'b000, now.mon}));
                  end else begin
                     nxt.mon = 5'h01;
                     if (now.yr != 8'h99) begin
                        nxt.yr = bcd_step(now.yr);
                     end else begin
                        nxt.yr  = 8'h00;
                        nxt.cen = (now.cen >= 6'h39) ? 6'h00 : 6'(bcd_step({2'b00, now.cen}));
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    now <= START;
      else if (load) now <= load_val;
      else if (adv)  now <= nxt;
   end
endmodule

// File: rtl/tkram_regs.sv
module tkram_regs
   import tkram_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] idx,
   input  logic [7:0] wdata,
   input  tk_time_t   cur,
   input  logic       hz512_tick,
   input  logic       batt_ok,
   output logic [7:0] rd_byte,
   output logic       load,
   output tk_time_t   load_val,
   output logic       osc_run
);
   logic [REG_CNT-1:0][7:0] ureg;
   logic                    halted;
   logic                    refresh;
   logic                    sq;
   logic                    ft;

   assign halted  = ureg[IX_CTRL][7] | ureg[IX_CTRL][6];
   assign refresh = !halted && !load;
   assign osc_run = !ureg[IX_SEC][7];
   assign ft      = ureg[IX_DAY][6];

   genvar gi;
   generate
      for (gi = 0; gi < REG_CNT; gi++) begin : g_byte
         localparam logic [2:0] IX = 3'(gi);
         localparam logic [7:0] TM = time_mask(IX);
         localparam logic [7:0] CM = ctl_mask(IX);
         localparam logic [7:0] RO = ro_mask(IX);
         localparam logic [7:0] RM = ~(TM | CM | RO);

         logic [7:0] q;
         logic [7:0] d;
         logic [7:0] wm;

         always_comb begin
            d  = q;
            wm = RM | CM | (halted ? TM : 8'h00);
            if (refresh) d = (q & ~TM) | (time_field(cur, IX) & TM);
            if (wr_en && idx == IX) d = (d & ~wm) | (wdata & wm);
         end

         always_ff @(posedge clk) begin
            if (!rst_n) q <= 8'h00;
            else        q <= d;
         end

         assign ureg[gi] = q;
      end
   endgenerate

   // set bit falling through a control write: transfer next cycle
   always_ff @(posedge clk) begin
      if (!rst_n) load <= 1'b0;
      else        load <= wr_en && (idx == IX_CTRL) && ureg[IX_CTRL][7] && !wdata[7];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    sq <= 1'b0;
      else if (hz512_tick && osc_run) sq <= ~sq;
   end

   always_comb begin
      load_val.cen  = ureg[IX_CTRL][5:0];
      load_val.sc   = ureg[IX_SEC][6:0];
      load_val.mn   = ureg[IX_MIN][6:0];
      load_val.hr   = ureg[IX_HOUR][5:0];
      load_val.dow  = ureg[IX_DAY][2:0];
      load_val.date = ureg[IX_DATE][5:0];
      load_val.mon  = ureg[IX_MON][4:0];
      load_val.yr   = ureg[IX_YEAR];
   end

   always_comb begin
      rd_byte = ureg[idx];
      if (idx == IX_DAY) rd_byte[7] = batt_ok;
      if (idx == IX_SEC && ft && osc_run) rd_byte[0] = sq;
   end
endmodule

// File: rtl/tkram_top.sv
module tkram_top
   import tkram_pkg::*;
#(
   parameter int ADDR_W        = 11,
   parameter bit STORE_OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   input  logic              sec_tick,
   input  logic              hz512_tick,
   input  logic              batt_ok
);
   generate
      if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_addr_w
         $error("tkram_top: ADDR_W must lie in 4..16");
      end
   endgenerate

   logic       in_win;
   logic       acc_wr;
   logic       acc_rd;
   logic [7:0] mem_q;
   logic [7:0] reg_byte;
   logic [7:0] reg_q;
   logic       win_q;
   logic       osc_run;
   logic       cal_load;
   tk_time_t   load_val;
   tk_time_t   cal_now;

   assign in_win = &addr[ADDR_W-1:3];
   assign acc_wr = !ce_n && !we_n;
   assign acc_rd = !ce_n && we_n && !oe_n;

   tkram_store #(.ADDR_W(ADDR_W), .OUT_REG(STORE_OUT_REG)) u_store (
      .clk   (clk),
      .we    (acc_wr && !in_win),
      .re    (acc_rd),
      .addr  (addr),
      .wdata (wdata),
      .q     (mem_q)
   );

   tkram_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (acc_wr && in_win),
      .idx        (addr[2:0]),
      .wdata      (wdata),
      .cur        (cal_now),
      .hz512_tick (hz512_tick),
      .batt_ok    (batt_ok),
      .rd_byte    (reg_byte),
      .load       (cal_load),
      .load_val   (load_val),
      .osc_run    (osc_run)
   );

   tkram_calendar u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (sec_tick && osc_run),
      .load     (cal_load),
      .load_val (load_val),
      .now      (cal_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         win_q    <= 1'b0;
         reg_q    <= 8'h00;
      end else begin
         rd_valid <= acc_rd;
         if (acc_rd) begin
            win_q <= in_win;
            reg_q <= reg_byte;
         end
      end
   end

   assign rd_data = !rd_valid ? 8'h00 : (win_q ? reg_q : mem_q);
endmodule

// File: rtl/tkram_chk.sv
module tkram_chk
   import tkram_pkg::*;
(
   input logic     clk,
   input logic     rst_n,
   input logic     ce_n,
   input logic     we_n,
   input logic     oe_n,
   input logic     sec_tick,
   input logic     rd_valid,
   input logic     osc_run,
   input logic     cal_load,
   input tk_time_t load_val,
   input tk_time_t cal_now
);
   // R1: valid data only follows a read access
   a_r1_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!ce_n && we_n && !oe_n));

   // R13: deselected cycle yields no read
   a_r13_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce_n) |-> !rd_valid);

   // R4: counters move only on a tick or a transfer
   a_r4_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !cal_load) |=> $stable(cal_now));

   // R10: stopped oscillator freezes the counters
   a_r10_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_run && !cal_load) |=> $stable(cal_now));

   // R5: transfer copies staged values into the counters
   a_r5_transfer_lands: assert property (@(posedge clk) disable iff (!rst_n)
      cal_load |=> (cal_now == $past(load_val)));
endmodule

bind tkram_top tkram_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_n     (ce_n),
   .we_n     (we_n),
   .oe_n     (oe_n),
   .sec_tick (sec_tick),
   .rd_valid (rd_valid),
   .osc_run  (osc_run),
   .cal_load (cal_load),
   .load_val (load_val),
   .cal_now  (cal_now)
);

// File: tb/sim_tkram_top.sv
`timescale 1ns/1ps
module sim_tkram_top;
   localparam int AW = 11;
   localparam logic [AW-1:0] A_CTRL = 11'h7F8;
   localparam logic [AW-1:0] A_SEC  = 11'h7F9;
   localparam logic [AW-1:0] A_MIN  = 11'h7FA;
   localparam logic [AW-1:0] A_HOUR = 11'h7FB;
   localparam logic [AW-1:0] A_DAY  = 11'h7FC;
   localparam logic [AW-1:0] A_DATE = 11'h7FD;
   localparam logic [AW-1:0] A_MON  = 11'h7FE;
   localparam logic [AW-1:0] A_YEAR = 11'h7FF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = 8'h00;
   logic [7:0]    rd_data;
   logic          rd_valid;
   logic          sec_tick = 1'b0, hz512_tick = 1'b0, batt_ok = 1'b1;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   tkram_top #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
      .sec_tick(sec_tick), .hz512_tick(hz512_tick), .batt_ok(batt_ok)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
      idle(3);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
      @(negedge clk);
      d = rd_data;
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) sec_tick = 1'b1;
         @(negedge clk) sec_tick = 1'b0;
      end
      idle(2);
   endtask

   task automatic fast();
      @(negedge clk) hz512_tick = 1'b1;
      @(negedge clk) hz512_tick = 1'b0;
      idle(1);
   endtask

   task automatic set_time(input logic [7:0] cen, input logic [7:0] yr, input logic [7:0] mon,
                           input logic [7:0] dt, input logic [7:0] dw, input logic [7:0] hr,
                           input logic [7:0] mn, input logic [7:0] sc);
      wr(A_CTRL, 8'h80);
      wr(A_YEAR, yr); wr(A_MON, mon); wr(A_DATE, dt); wr(A_DAY, dw);
      wr(A_HOUR, hr); wr(A_MIN, mn); wr(A_SEC, sc);
      wr(A_CTRL, cen);
   endtask

   task automatic t_reset();
      chk("R1 reset rd_valid", {7'd0, rd_valid}, 8'h00);
      chk("R1 reset rd_data", rd_data, 8'h00);
      idle(2);
      rd_chk("R3 reset century", A_CTRL, 8'h20);
      rd_chk("R3 reset year", A_YEAR, 8'h00);
      rd_chk("R3 reset month", A_MON, 8'h01);
      rd_chk("R3 reset date", A_DATE, 8'h01);
      rd_chk("R3 reset weekday", A_DAY, 8'h81);
      rd_chk("R3 reset hour", A_HOUR, 8'h00);
      rd_chk("R3 reset seconds", A_SEC, 8'h00);
   endtask

   task automatic t_sram();
      wr(11'h000, 8'h5A); wr(11'h7F7, 8'hC3); wr(11'h123, 8'hA5);
      wr(A_MIN, 8'h80);
      rd_chk("R2 sram low", 11'h000, 8'h5A);
      rd_chk("R2 sram below window", 11'h7F7, 8'hC3);
      rd_chk("R2 sram mid", 11'h123, 8'hA5);
      wr(A_MIN, 8'h00);
   endtask

   task automatic t_deselect();
      logic [7:0] v;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b0; addr = 11'h123; wdata = 8'hFF;
      @(negedge clk);
      we_n = 1'b1; oe_n = 1'b0;
      @(negedge clk);
      chk("R13 no read when deselected", {7'd0, rd_valid}, 8'h00);
      oe_n = 1'b1;
      rd(11'h123, v);
      chk("R13 no write when deselected", v, 8'hA5);
   endtask

   task automatic t_count();
      tick(3);
      rd_chk("R4 three ticks", A_SEC, 8'h03);
      tick(12);
      rd_chk("R4 bcd carry", A_SEC, 8'h15);
   endtask

   task automatic t_spare();
      wr(A_SEC, 8'h42);
      rd_chk("R8 seconds write ignored", A_SEC, 8'h15);
      wr(A_HOUR, 8'hC5);
      rd_chk("R9 hour spare bits", A_HOUR, 8'hC0);
      wr(A_MON, 8'hE9);
      rd_chk("R9 month spare bits", A_MON, 8'hE1);
      wr(A_DAY, 8'h38);
      rd_chk("R9 weekday spare bits", A_DAY, 8'hB9);
      wr(A_HOUR, 8'h00); wr(A_MON, 8'h00); wr(A_DAY, 8'h00);
   endtask

   task automatic t_set_roll();
      set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      rd_chk("R5 loaded seconds", A_SEC, 8'h59);
      rd_chk("R5 loaded year", A_YEAR, 8'h23);
      tick(1);
      rd_chk("R6 seconds wrap", A_SEC, 8'h00);
      rd_chk("R6 minutes wrap", A_MIN, 8'h00);
      rd_chk("R6 hours wrap", A_HOUR, 8'h00);
      rd_chk("R6 feb end plain year", A_DATE, 8'h01);
      rd_chk("R6 month carry", A_MON, 8'h03);
      rd_chk("R6 weekday step", A_DAY, 8'h84);
   endtask

   task automatic t_leap();
      set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59);
      tick(1);
      rd_chk("R6 leap day", A_DATE, 8'h29);
      rd_chk("R6 leap month held", A_MON, 8'h02);
   endtask

   task automatic t_century();
      set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
      tick(1);
      rd_chk("R6 century carry", A_CTRL, 8'h21);
      rd_chk("R6 year wrap", A_YEAR, 8'h00);
      rd_chk("R6 month wrap", A_MON, 8'h01);
      rd_chk("R6 date wrap", A_DATE, 8'h01);
      rd_chk("R6 weekday wrap", A_DAY, 8'h81);
   endtask

   task automatic t_freeze();
      wr(A_CTRL, 8'h40);
      tick(3);
      rd_chk("R7 frozen seconds", A_SEC, 8'h00);
      rd_chk("R7 control while frozen", A_CTRL, 8'h61);
      wr(A_CTRL, 8'h00);
      rd_chk("R7 seconds after release", A_SEC, 8'h03);
      rd_chk("R7 century after release", A_CTRL, 8'h21);
   endtask

   task automatic t_stop();
      wr(A_SEC, 8'h80);
      tick(2);
      rd_chk("R10 stopped seconds", A_SEC, 8'h83);
      wr(A_SEC, 8'h00);
      tick(1);
      rd_chk("R10 restarted seconds", A_SEC, 8'h04);
   endtask

   task automatic t_ftest();
      wr(A_DAY, 8'h40);
      rd_chk("R11 wave low", A_SEC, 8'h04);
      fast();
      rd_chk("R11 wave high", A_SEC, 8'h05);
      fast();
      rd_chk("R11 wave low again", A_SEC, 8'h04);
      fast();
      wr(A_SEC, 8'h80);
      rd_chk("R11 no wave when stopped", A_SEC, 8'h84);
      wr(A_SEC, 8'h00);
      wr(A_DAY, 8'h00);
   endtask

   task automatic t_batt();
      batt_ok = 1'b0;
      rd_chk("R12 flag low", A_DAY, 8'h01);
      wr(A_DAY, 8'h80);
      rd_chk("R12 flag not writable", A_DAY, 8'h01);
      batt_ok = 1'b1;
      rd_chk("R12 flag high", A_DAY, 8'h81);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sram();
      t_deselect();
      t_count();
      t_spare();
      t_set_roll();
      t_leap();
      t_century();
      t_freeze();
      t_stop();
      t_ftest();
      t_batt();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule